// File: doc/BRIEF.md
# Sequenced Key Unlock Guard

This block stands in front of an indirect register window (an address register and a data register) and keeps it closed until the host proves intent by writing a fixed two-byte key into a key register. The first byte must be 0xA5 and the second 0xF1. Any number of idle cycles may separate the two writes. After the second byte is accepted the window is open, and the host may read and write the protected registers as often as it likes.

Protocol mistakes are punished hard. A wrong byte, the keys in the wrong order, or any touch of the protected registers before the window is open sends the guard into a disabled state. Only a reset clears that state. When the window is open, any key-register write closes it again and the sequence restarts from the first byte. A key-register read returns a status code and never disturbs the sequence.

The guard drives a gated copy of each protected-access strobe. The gated copy passes only while the window is open. The register file behind the window is not part of this block.

Top module: `key_unlock_guard`

## Requirements
- R1: During and after a synchronous reset, the guard waits for the first key (code 0), both flags are low, and the status byte reads 0.
- R2: Writing 0xA5 while at code 0 moves the guard to code 1. Writing 0xF1 while at code 1 moves it to code 2 (open). The state changes on the clock edge that samples the key write. Idle gaps of any length between the two writes are allowed.
- R3: At code 0, a key write of any value other than 0xA5 moves the guard to code 3 (disabled). At code 1, a key write of any value other than 0xF1 does the same. This includes a repeated 0xA5 and 0xF1 written first.
- R4: Any address or data read or write strobe seen while the guard is not at code 2 moves it to code 3. Such a strobe is never passed to its gated output. An access strobe takes priority over a key write in the same cycle.
- R5: At code 2, every access strobe is passed unchanged, in the same cycle, to its gated output. Accesses do not change the state, however many there are.
- R6: At code 2, a key write of any value returns the guard to code 0 on the next edge.
- R7: A key-register read loads the status byte on the next edge with the code held before that edge: bits [1:0] carry the code and the upper bits are zero. Between reads the status byte holds its value. A read never changes the state.
- R8: At code 3, key writes and access strobes are ignored, the gated outputs stay low, and the guard stays at code 3 until reset.
- R9: The unlocked flag is high exactly at code 2 and the disabled flag is high exactly at code 3. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| key_wr | input | 1 | Key register write strobe |
| key_wdata | input | 8 | Key register write data |
| key_rd | input | 1 | Key register read strobe |
| adr_rd | input | 1 | Protected address register read attempt |
| adr_wr | input | 1 | Protected address register write attempt |
| dat_rd | input | 1 | Protected data register read attempt |
| dat_wr | input | 1 | Protected data register write attempt |
| adr_rd_ok | output | 1 | Gated address read strobe |
| adr_wr_ok | output | 1 | Gated address write strobe |
| dat_rd_ok | output | 1 | Gated data read strobe |
| dat_wr_ok | output | 1 | Gated data write strobe |
| unlocked | output | 1 | Window open (code 2) |
| disabled | output | 1 | Guard disabled until reset (code 3) |
| key_status | output | 8 | Status byte loaded by key reads |

## Verification
The assertions assume that every input is a clean, single-cycle-sampled level on the clock and that reset is the only thing that leaves the disabled state. They do not assume the host follows the protocol, so access strobes, key writes and reads may coincide in any combination. The random stimulus biases key data toward 0xA5 and 0xF1 so that the window does open. It keeps access strobes rare so that open periods last, and it pulses reset now and then so that runs do not stay stuck in the disabled state.

// File: rtl/key_guard_pkg.sv
package key_guard_pkg;

    localparam int KEY_W  = 8;
    localparam int STAT_W = 8;
    localparam int N_ACC  = 4;

    typedef enum logic [1:0] {
        GS_WAIT_FIRST  = 2'd0,
        GS_WAIT_SECOND = 2'd1,
        GS_OPEN        = 2'd2,
        GS_DEAD        = 2'd3
    } guard_state_e;

    typedef struct packed {
        logic             wr;
        logic [KEY_W-1:0] data;
    } key_write_t;

    function automatic logic [STAT_W-1:0] code_byte(guard_state_e s);
        logic [STAT_W-1:0] b;
        b = '0;
        b[1:0] = s;
        return b;
    endfunction

endpackage

// File: rtl/key_seq_fsm.sv
module key_seq_fsm
    import key_guard_pkg::*;
#(
    parameter logic [KEY_W-1:0] FIRST_KEY  = 8'hA5,
    parameter logic [KEY_W-1:0] SECOND_KEY = 8'hF1
) (
    input  logic         clk,
    input  logic         rst,
    input  key_write_t   kw,
    input  logic         access_any,
    output guard_state_e state
);

    guard_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (state_q != GS_DEAD) begin
            if (access_any && state_q != GS_OPEN) begin
                state_d = GS_DEAD;
            end else if (kw.wr) begin
                unique case (state_q)
                    GS_WAIT_FIRST:  state_d = (kw.data == FIRST_KEY)  ? GS_WAIT_SECOND : GS_DEAD;
                    GS_WAIT_SECOND: state_d = (kw.data == SECOND_KEY) ? GS_OPEN : GS_DEAD;
                    GS_OPEN:        state_d = GS_WAIT_FIRST;
                    default:        state_d = GS_DEAD;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GS_WAIT_FIRST;
        else     state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/access_gate.sv
module access_gate
    import key_guard_pkg::*;
#(
    parameter int N = N_ACC
) (
    input  guard_state_e state,
    input  logic [N-1:0] req,
    output logic [N-1:0] pass,
    output logic         any_req
);

    logic open_now;
    assign open_now = (state == GS_OPEN);
    assign any_req  = |req;

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign pass[i] = req[i] & open_now;
    end

endmodule

// File: rtl/status_port.sv
module status_port
    import key_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  guard_state_e      state,
    output logic [STAT_W-1:0] rdata,
    output logic              unlocked,
    output logic              disabled
);

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= code_byte(state);
    end

    assign unlocked = (state == GS_OPEN);
    assign disabled = (state == GS_DEAD);

endmodule

// File: rtl/key_unlock_guard.sv
module key_unlock_guard
    import key_guard_pkg::*;
#(
    parameter logic [KEY_W-1:0] FIRST_KEY  = 8'hA5,
    parameter logic [KEY_W-1:0] SECOND_KEY = 8'hF1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [KEY_W-1:0]  key_wdata,
    input  logic              key_rd,
    input  logic              adr_rd,
    input  logic              adr_wr,
    input  logic              dat_rd,
    input  logic              dat_wr,
    output logic              adr_rd_ok,
    output logic              adr_wr_ok,
    output logic              dat_rd_ok,
    output logic              dat_wr_ok,
    output logic              unlocked,
    output logic              disabled,
    output logic [STAT_W-1:0] key_status
);

    guard_state_e     state;
    key_write_t       kw;
    logic [N_ACC-1:0] req, pass;
    logic             access_any;
    logic [1:0]       state_code;

    assign kw.wr      = key_wr;
    assign kw.data    = key_wdata;
    assign req        = {dat_wr, dat_rd, adr_wr, adr_rd};
    assign state_code = state;

    key_seq_fsm #(
        .FIRST_KEY  (FIRST_KEY),
        .SECOND_KEY (SECOND_KEY)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .kw         (kw),
        .access_any (access_any),
        .state      (state)
    );

    access_gate #(.N(N_ACC)) u_gate (
        .state   (state),
        .req     (req),
        .pass    (pass),
        .any_req (access_any)
    );

    status_port u_stat (
        .clk      (clk),
        .rst      (rst),
        .rd       (key_rd),
        .state    (state),
        .rdata    (key_status),
        .unlocked (unlocked),
        .disabled (disabled)
    );

    assign {dat_wr_ok, dat_rd_ok, adr_wr_ok, adr_rd_ok} = pass;

endmodule

// File: rtl/key_guard_checker.sv
module key_guard_checker (
    input logic       clk,
    input logic       rst,
    input logic       key_wr,
    input logic       key_rd,
    input logic       acc_any,
    input logic [3:0] gated,
    input logic       unlocked,
    input logic       disabled,
    input logic [1:0] state_code
);

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(unlocked && disabled));

    assert_dead_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        disabled |=> disabled);

    assert_locked_access_kills_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_any && !unlocked) |=> disabled);

    assert_gate_needs_open_R5: assert property (@(posedge clk) disable iff (rst)
        (gated != 4'd0) |-> unlocked);

    assert_relock_R6: assert property (@(posedge clk) disable iff (rst)
        (unlocked && key_wr) |=> (state_code == 2'd0));

    assert_read_no_effect_R7: assert property (@(posedge clk) disable iff (rst)
        (key_rd && !key_wr && !acc_any) |=> $stable(state_code));

    assert_open_only_from_second_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> ($past(state_code) == 2'd1));

endmodule

bind key_unlock_guard key_guard_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .key_wr     (key_wr),
    .key_rd     (key_rd),
    .acc_any    (adr_rd | adr_wr | dat_rd | dat_wr),
    .gated      ({dat_wr_ok, dat_rd_ok, adr_wr_ok, adr_rd_ok}),
    .unlocked   (unlocked),
    .disabled   (disabled),
    .state_code (state_code)
);

// File: tb/key_unlock_guard_tb.sv
module key_unlock_guard_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_wr = 1'b0, key_rd = 1'b0;
    logic [7:0] key_wdata = 8'h00;
    logic       adr_rd = 1'b0, adr_wr = 1'b0, dat_rd = 1'b0, dat_wr = 1'b0;
    logic       adr_rd_ok, adr_wr_ok, dat_rd_ok, dat_wr_ok;
    logic       unlocked, disabled;
    logic [7:0] key_status;

    int n_tests = 0, n_fail = 0;
    int exp_st = 0;
    int exp_rd = 0;
    bit done = 0;

    always #5 clk = ~clk;

    key_unlock_guard u_dut (
        .clk(clk), .rst(rst), .key_wr(key_wr), .key_wdata(key_wdata), .key_rd(key_rd),
        .adr_rd(adr_rd), .adr_wr(adr_wr), .dat_rd(dat_rd), .dat_wr(dat_wr),
        .adr_rd_ok(adr_rd_ok), .adr_wr_ok(adr_wr_ok), .dat_rd_ok(dat_rd_ok), .dat_wr_ok(dat_wr_ok),
        .unlocked(unlocked), .disabled(disabled), .key_status(key_status)
    );

    function automatic int model_next(int s, bit kw, int d, bit acc);
        if (s == 3) return 3;
        if (acc && s != 2) return 3;
        if (kw) begin
            if (s == 0) return (d == 8'hA5) ? 1 : 3;
            if (s == 1) return (d == 8'hF1) ? 2 : 3;
            return 0;
        end
        return s;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_flags(string tag);
        check(tag, {30'd0, unlocked, disabled}, {30'd0, exp_st == 2, exp_st == 3});
        check("R7", key_status, exp_rd);
    endtask

    task automatic step(bit kw, int d, bit rd, bit [3:0] acc, string tag);
        bit [3:0] want;
        @(negedge clk);
        key_wr = kw; key_wdata = d[7:0]; key_rd = rd;
        {dat_wr, dat_rd, adr_wr, adr_rd} = acc;
        #1;
        want = (exp_st == 2) ? acc : 4'd0;
        check((exp_st == 2) ? "R5" : ((exp_st == 3) ? "R8" : "R4"),
              {dat_wr_ok, dat_rd_ok, adr_wr_ok, adr_rd_ok}, want);
        @(posedge clk);
        if (rd) exp_rd = exp_st;
        exp_st = model_next(exp_st, kw, d, |acc);
        #1;
        key_wr = 0; key_rd = 0; {dat_wr, dat_rd, adr_wr, adr_rd} = 4'd0;
        check_flags(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(posedge clk); @(posedge clk);
        #1;
        exp_st = 0; exp_rd = 0;
        check_flags("R1");
        @(negedge clk);
        rst = 0;
    endtask

    task automatic read_code(int want, string tag);
        step(0, 0, 1, 4'd0, tag);
        check(tag, key_status, want);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        do_reset();
        check("R1", key_status, 0);

        // R2: keys with a long gap, then R7 read shows code 1 then 2
        step(1, 8'hA5, 0, 4'd0, "R2");
        read_code(1, "R2");
        repeat (40) step(0, 0, 0, 4'd0, "R2");
        step(1, 8'hF1, 0, 4'd0, "R2");
        read_code(2, "R2");

        // R5: many accesses while open
        for (int i = 0; i < 16; i++) step(0, 0, 0, i[3:0], "R5");
        check("R5", {31'd0, unlocked}, 1);

        // R6: any write relocks, even the first key value
        step(1, 8'hA5, 0, 4'd0, "R6");
        read_code(0, "R6");

        // R3: second key first
        step(1, 8'hF1, 0, 4'd0, "R3");
        read_code(3, "R3");
        // R8: ignored while disabled
        step(1, 8'hA5, 0, 4'd0, "R8");
        step(1, 8'hF1, 0, 4'hF, "R8");
        read_code(3, "R8");

        // R3: repeated first key
        do_reset();
        step(1, 8'hA5, 0, 4'd0, "R3");
        step(1, 8'hA5, 0, 4'd0, "R3");
        check("R3", {31'd0, disabled}, 1);

        // R4: access while waiting second key, with key write same cycle
        do_reset();
        step(1, 8'hA5, 0, 4'd0, "R2");
        step(1, 8'hF1, 0, 4'b0100, "R4");
        check("R4", {31'd0, disabled}, 1);

        // R4: access at code 0
        do_reset();
        step(0, 0, 1, 4'b1000, "R4");
        read_code(3, "R4");

        // R7: read in the same cycle as the first key returns old code
        do_reset();
        step(1, 8'hA5, 1, 4'd0, "R7");
        check("R7", key_status, 0);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            int r, d;
            bit kw, rd;
            bit [3:0] acc;
            r = $urandom_range(0, 99);
            if (r < 2) begin
                do_reset();
                continue;
            end
            kw = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 3))
                0, 1: d = (exp_st == 1) ? 8'hF1 : 8'hA5;
                2:    d = 8'hF1;
                default: d = $urandom_range(0, 255);
            endcase
            rd = ($urandom_range(0, 4) == 0);
            acc = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
            step(kw, d, rd, acc, "R9");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule